// File: doc/BRIEF.md
# Home Directory Controller for Cache Coherence

This block is the home-node directory of a small distributed shared-memory system with four processors. For every memory block it owns, it keeps a coherence state, a bit-vector of the processors that hold a copy, and the block's two data words. Caches send it four kinds of request: read miss, write miss, invalidate (an upgrade from a shared copy) and data write-back. The directory answers with data replies, invalidates, fetches and fetch-with-invalidate messages, and it keeps its state and sharer vector up to date.

Requests are handled one at a time. While the directory is sending a series of invalidates, it accepts nothing. While it is waiting for an owner to return a modified block, the only request it accepts is that owner's write-back for that block. The outgoing message port sends one message per cycle and has no backpressure.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is uncached, with an empty sharer vector and zero data. `req_ready` is high and `msg_valid` is low.
- R2: A read miss on an uncached or shared entry produces a data reply with the stored data to the requester in the cycle after acceptance. The requester joins the sharers and the entry becomes shared.
- R3: A read miss on a modified entry sends a fetch to the owner. When the owner's write-back is accepted, memory takes its data and the requester gets a data reply carrying that data. The entry becomes shared, with both the owner and the requester as sharers.
- R4: A write miss on a modified entry sends a fetch-with-invalidate to the owner. After the owner's write-back, the requester gets a data reply with the written-back data and becomes the only owner of the modified entry.
- R5: A write miss on a shared entry sends one invalidate per cycle, starting the cycle after acceptance, to each sharer other than the requester, in ascending processor number. The data reply follows in the next cycle. The entry becomes modified, owned by the requester.
- R6: An invalidate request on a shared entry sends the same invalidate series and then no reply. The requester becomes the owner of the modified entry.
- R7: A write miss or invalidate request on an uncached entry produces a data reply in the cycle after acceptance. The entry becomes modified, owned by the requester.
- R8: A write-back from the owner of a modified entry, outside a fetch, stores its data, makes the entry uncached with no sharers, and sends no message.
- R9: A write-back from any other processor stores its data, leaves state and sharers unchanged, and sends no message.
- R10: While invalidates are pending, `req_ready` is low. While waiting for a fetched block, `req_ready` is high only for a write-back from the current owner to the block being served.
- R11: Encodings. Request kind: 0 read miss, 1 write miss, 2 invalidate, 3 write-back. Message kind: 0 data reply, 1 invalidate, 2 fetch, 3 fetch-with-invalidate. `msg_data` is zero on any message that is not a data reply. Data words are packed with word 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind (R11) |
| req_src | input | 2 | Requesting processor |
| req_addr | input | 3 | Block index |
| req_data | input | 16 | Write-back data (two 8-bit words) |
| req_ready | output | 1 | Request accepted at this edge if valid |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 2 | Message kind (R11) |
| msg_dest | output | 2 | Destination processor |
| msg_addr | output | 3 | Block index of the message |
| msg_data | output | 16 | Reply data, zero otherwise |

## Verification
The bench uses the default parameters: four processors, eight blocks and two 8-bit words per block. With four processors, a shared block can have up to three sharers besides the requester, so the invalidate ordering is observable and the skip of the requester can be seen in the middle of the series. With eight blocks, each scenario can run on a fresh uncached entry. State that cannot be read directly, such as ownership after an eviction or after a non-owner write-back, is exposed by a later request: whether that request gets a fetch or an immediate data reply shows the entry's state.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        RQ_RD_MISS = 2'd0,
        RQ_WR_MISS = 2'd1,
        RQ_INVAL   = 2'd2,
        RQ_WRBACK  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA      = 2'd0,
        MS_INVAL     = 2'd1,
        MS_FETCH     = 2'd2,
        MS_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_MOD = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INVS = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    parameter int AW    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          rd_addr,
    output dir_state_e             rd_state,
    output logic [NPROC-1:0]       rd_sharers,
    output logic [DW-1:0]          rd_data,
    input  logic                   we,
    input  logic [AW-1:0]          wr_addr,
    input  dir_state_e             wr_state,
    input  logic [NPROC-1:0]       wr_sharers,
    input  logic [DW-1:0]          wr_data
);

    dir_state_e       st_q  [NBLK];
    logic [NPROC-1:0] shr_q [NBLK];
    logic [DW-1:0]    dat_q [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                st_q[i]  <= DIR_UNC;
                shr_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (we) begin
            st_q[wr_addr]  <= wr_state;
            shr_q[wr_addr] <= wr_sharers;
            dat_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_state   = st_q[rd_addr];
        rd_sharers = shr_q[rd_addr];
        rd_data    = dat_q[rd_addr];
    end

endmodule

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
    parameter int NPROC = 4,
    parameter int PID_W = 2
) (
    input  logic [NPROC-1:0] vec,
    output logic [PID_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (vec[i]) idx = PID_W'(i);
        end
    end

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int PID_W = 2,
    parameter int AW    = 3,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [PID_W-1:0] req_src,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    output logic             req_ready,
    output logic [AW-1:0]    rd_addr,
    input  dir_state_e       ent_state,
    input  logic [NPROC-1:0] ent_sharers,
    input  logic [DW-1:0]    ent_data,
    output logic             we,
    output logic [AW-1:0]    wr_addr,
    output dir_state_e       wr_state,
    output logic [NPROC-1:0] wr_sharers,
    output logic [DW-1:0]    wr_data,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [PID_W-1:0] msg_dest,
    output logic [AW-1:0]    msg_addr,
    output logic [DW-1:0]    msg_data,
    output phase_e           phase
);

    localparam logic [NPROC-1:0] ONE_P = NPROC'(1);

    phase_e           phase_q, phase_n;
    logic [AW-1:0]    cur_addr_q, cur_addr_n;
    logic [PID_W-1:0] cur_src_q, cur_src_n;
    req_kind_e        cur_kind_q, cur_kind_n;
    logic [NPROC-1:0] pend_q, pend_n;
    logic             mv_n;
    msg_kind_e        mk_n;
    logic [PID_W-1:0] mdest_n;
    logic [AW-1:0]    maddr_n;
    logic [DW-1:0]    md_n;

    logic [PID_W-1:0] own_idx, pend_idx;
    logic             own_any, pend_any;
    logic [NPROC-1:0] src_bit, cur_bit;
    req_kind_e        kind_in;
    logic             fire;

    coh_dir_pick #(.NPROC(NPROC), .PID_W(PID_W)) own_pick_i (
        .vec(ent_sharers), .idx(own_idx), .any(own_any)
    );

    coh_dir_pick #(.NPROC(NPROC), .PID_W(PID_W)) pend_pick_i (
        .vec(pend_q), .idx(pend_idx), .any(pend_any)
    );

    always_comb begin
        kind_in = req_kind_e'(req_kind);
        src_bit = '0;
        src_bit[req_src] = 1'b1;
        cur_bit = '0;
        cur_bit[cur_src_q] = 1'b1;
        rd_addr = (phase_q == PH_IDLE) ? req_addr : cur_addr_q;
        case (phase_q)
            PH_IDLE: req_ready = 1'b1;
            PH_WAIT: req_ready = (kind_in == RQ_WRBACK) && own_any &&
                                 (req_src == own_idx) && (req_addr == cur_addr_q);
            default: req_ready = 1'b0;
        endcase
        fire = req_valid && req_ready;
    end

    always_comb begin
        phase_n    = phase_q;
        cur_addr_n = cur_addr_q;
        cur_src_n  = cur_src_q;
        cur_kind_n = cur_kind_q;
        pend_n     = pend_q;
        we         = 1'b0;
        wr_addr    = rd_addr;
        wr_state   = ent_state;
        wr_sharers = ent_sharers;
        wr_data    = ent_data;
        mv_n       = 1'b0;
        mk_n       = MS_DATA;
        mdest_n    = cur_src_q;
        maddr_n    = cur_addr_q;
        md_n       = '0;
        case (phase_q)
            PH_IDLE: begin
                if (fire) begin
                    cur_addr_n = req_addr;
                    cur_src_n  = req_src;
                    cur_kind_n = kind_in;
                    maddr_n    = req_addr;
                    mdest_n    = req_src;
                    if (kind_in == RQ_WRBACK) begin
                        we      = 1'b1;
                        wr_data = req_data;
                        if (ent_state == DIR_MOD && ent_sharers == src_bit) begin
                            wr_state   = DIR_UNC;
                            wr_sharers = '0;
                        end
                    end else if (kind_in == RQ_RD_MISS) begin
                        if (ent_state == DIR_MOD) begin
                            mv_n    = 1'b1;
                            mk_n    = MS_FETCH;
                            mdest_n = own_idx;
                            phase_n = PH_WAIT;
                        end else begin
                            mv_n       = 1'b1;
                            md_n       = ent_data;
                            we         = 1'b1;
                            wr_state   = DIR_SHR;
                            wr_sharers = ent_sharers | src_bit;
                        end
                    end else begin
                        if (ent_state == DIR_SHR) begin
                            we         = 1'b1;
                            wr_state   = DIR_MOD;
                            wr_sharers = src_bit;
                            pend_n     = ent_sharers & ~src_bit;
                            phase_n    = PH_INVS;
                        end else if (ent_state == DIR_MOD) begin
                            mv_n       = 1'b1;
                            mk_n       = MS_FETCH_INV;
                            mdest_n    = own_idx;
                            phase_n    = PH_WAIT;
                            cur_kind_n = RQ_WR_MISS;
                        end else begin
                            mv_n       = 1'b1;
                            md_n       = ent_data;
                            we         = 1'b1;
                            wr_state   = DIR_MOD;
                            wr_sharers = src_bit;
                        end
                    end
                end
            end
            PH_INVS: begin
                if (pend_any) begin
                    mv_n    = 1'b1;
                    mk_n    = MS_INVAL;
                    mdest_n = pend_idx;
                    pend_n  = pend_q & (pend_q - ONE_P);
                end else begin
                    phase_n = PH_IDLE;
                    if (cur_kind_q == RQ_WR_MISS) begin
                        mv_n = 1'b1;
                        md_n = ent_data;
                    end
                end
            end
            PH_WAIT: begin
                if (fire) begin
                    we      = 1'b1;
                    wr_data = req_data;
                    if (cur_kind_q == RQ_RD_MISS) begin
                        wr_state   = DIR_SHR;
                        wr_sharers = ent_sharers | cur_bit;
                    end else begin
                        wr_state   = DIR_MOD;
                        wr_sharers = cur_bit;
                    end
                    mv_n    = 1'b1;
                    md_n    = req_data;
                    phase_n = PH_IDLE;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cur_addr_q <= '0;
            cur_src_q  <= '0;
            cur_kind_q <= RQ_RD_MISS;
            pend_q     <= '0;
            msg_valid  <= 1'b0;
            msg_kind   <= MS_DATA;
            msg_dest   <= '0;
            msg_addr   <= '0;
            msg_data   <= '0;
        end else begin
            phase_q    <= phase_n;
            cur_addr_q <= cur_addr_n;
            cur_src_q  <= cur_src_n;
            cur_kind_q <= cur_kind_n;
            pend_q     <= pend_n;
            msg_valid  <= mv_n;
            msg_kind   <= mk_n;
            msg_dest   <= mdest_n;
            msg_addr   <= maddr_n;
            msg_data   <= md_n;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NBLK   = 8,
    parameter int WORD_W = 8,
    parameter int NWORDS = 2,
    localparam int PID_W = $clog2(NPROC),
    localparam int AW    = $clog2(NBLK),
    localparam int DW    = WORD_W * NWORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [PID_W-1:0] req_src,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    output logic             req_ready,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [PID_W-1:0] msg_dest,
    output logic [AW-1:0]    msg_addr,
    output logic [DW-1:0]    msg_data
);

    logic [AW-1:0]    rd_addr, wr_addr;
    dir_state_e       ent_state, wr_state;
    logic [NPROC-1:0] ent_sharers, wr_sharers;
    logic [DW-1:0]    ent_data, wr_data;
    logic             we;
    phase_e           phase;

    coh_dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .AW(AW)) store_i (
        .clk(clk), .rst(rst),
        .rd_addr(rd_addr), .rd_state(ent_state), .rd_sharers(ent_sharers),
        .rd_data(ent_data),
        .we(we), .wr_addr(wr_addr), .wr_state(wr_state),
        .wr_sharers(wr_sharers), .wr_data(wr_data)
    );

    coh_dir_ctrl #(.NPROC(NPROC), .PID_W(PID_W), .AW(AW), .DW(DW)) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .rd_addr(rd_addr), .ent_state(ent_state), .ent_sharers(ent_sharers),
        .ent_data(ent_data),
        .we(we), .wr_addr(wr_addr), .wr_state(wr_state),
        .wr_sharers(wr_sharers), .wr_data(wr_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .phase(phase)
    );

endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk
    import coh_dir_pkg::*;
#(
    parameter int PID_W = 2,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             req_ready,
    input logic             msg_valid,
    input logic [1:0]       msg_kind,
    input logic [PID_W-1:0] msg_dest,
    input logic [DW-1:0]    msg_data,
    input phase_e           phase
);

    p_ctl_data_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != MS_DATA) |-> (msg_data == '0));

    p_inval_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INVAL &&
         $past(msg_valid) && $past(msg_kind) == MS_INVAL)
        |-> (msg_dest > $past(msg_dest)));

    p_invs_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INVS) |-> !req_ready);

    p_wait_only_wb_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && req_kind != RQ_WRBACK) |-> !req_ready);

    p_fetch_then_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && (msg_kind == MS_FETCH || msg_kind == MS_FETCH_INV))
        |-> (phase == PH_WAIT));

    p_wb_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && phase == PH_IDLE && req_kind == RQ_WRBACK)
        |=> !msg_valid);

endmodule

bind coh_home_dir coh_home_dir_chk #(.PID_W(PID_W), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_ready(req_ready), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_data(msg_data), .phase(phase)
);

// File: tb/coh_home_dir_tb_top.sv
`timescale 1ns/1ps
module coh_home_dir_tb_top;

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_INV = 2'd2, K_WB = 2'd3;
    localparam logic [1:0] M_DATA = 2'd0, M_INV = 2'd1, M_FET = 2'd2, M_FINV = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_ready;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dest;
    logic [2:0]  msg_addr;
    logic [15:0] msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    coh_home_dir dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [1:0] k, input int src, input int addr,
                        input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_src   = 2'(src);
        req_addr  = 3'(addr);
        req_data  = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_msg(input string tag, input logic [1:0] k, input int dest,
                              input int addr, input logic [15:0] d);
        logic [23:0] act, exp;
        act = {1'b1 & msg_valid, msg_kind, msg_dest, msg_addr, msg_data};
        exp = {1'b1, k, 2'(dest), 3'(addr), d};
        check(act == exp, tag, 32'(act), 32'(exp));
    endtask

    task automatic expect_none(input string tag);
        check(msg_valid == 1'b0, tag, 32'(msg_valid), 32'd0);
    endtask

    task automatic probe_ready(input string tag, input logic [1:0] k, input int src,
                               input int addr, input bit exp);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_src   = 2'(src);
        req_addr  = 3'(addr);
        #1;
        check(req_ready == exp, tag, 32'(req_ready), 32'(exp));
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        expect_none("R1 no message after reset");
        send(K_RD, 0, 0, '0);
        expect_msg("R1 R2 reset data zero reply", M_DATA, 0, 0, 16'h0000);
    endtask

    task automatic t_read_shared();
        send(K_WB, 0, 3, 16'hA1B2);
        expect_none("R9 write-back on uncached silent");
        send(K_RD, 1, 3, '0);
        expect_msg("R2 read miss uncached", M_DATA, 1, 3, 16'hA1B2);
        send(K_RD, 2, 3, '0);
        expect_msg("R2 read miss shared", M_DATA, 2, 3, 16'hA1B2);
    endtask

    task automatic t_write_shared();
        send(K_WR, 3, 3, '0);
        expect_none("R5 no message on accept cycle");
        check(req_ready == 1'b0, "R10 busy while invalidating", 32'(req_ready), 32'd0);
        step();
        expect_msg("R5 R11 first invalidate P1", M_INV, 1, 3, 16'h0);
        step();
        expect_msg("R5 second invalidate P2", M_INV, 2, 3, 16'h0);
        step();
        expect_msg("R5 reply after invalidates", M_DATA, 3, 3, 16'hA1B2);
    endtask

    task automatic t_read_modified();
        send(K_RD, 0, 3, '0);
        expect_msg("R3 fetch to owner P3", M_FET, 3, 3, 16'h0);
        probe_ready("R10 read blocked while waiting", K_RD, 1, 3, 1'b0);
        probe_ready("R10 non-owner write-back blocked", K_WB, 1, 3, 1'b0);
        probe_ready("R10 owner write-back accepted", K_WB, 3, 3, 1'b1);
        send(K_WB, 3, 3, 16'h5566);
        expect_msg("R3 reply with fetched data", M_DATA, 0, 3, 16'h5566);
        send(K_WR, 1, 3, '0);
        expect_none("R3 accept cycle");
        step();
        expect_msg("R3 sharer P0 invalidated", M_INV, 0, 3, 16'h0);
        step();
        expect_msg("R3 old owner P3 kept as sharer", M_INV, 3, 3, 16'h0);
        step();
        expect_msg("R5 reply to P1", M_DATA, 1, 3, 16'h5566);
    endtask

    task automatic t_write_modified();
        send(K_WR, 2, 3, '0);
        expect_msg("R4 R11 fetch-invalidate to P1", M_FINV, 1, 3, 16'h0);
        send(K_WB, 1, 3, 16'h7788);
        expect_msg("R4 reply with written-back data", M_DATA, 2, 3, 16'h7788);
        send(K_RD, 0, 3, '0);
        expect_msg("R4 new sole owner P2 fetched", M_FET, 2, 3, 16'h0);
        send(K_WB, 2, 3, 16'h7789);
        expect_msg("R3 reply after fetch", M_DATA, 0, 3, 16'h7789);
    endtask

    task automatic t_evict();
        send(K_WR, 1, 4, '0);
        expect_msg("R7 write miss on uncached", M_DATA, 1, 4, 16'h0);
        send(K_WB, 1, 4, 16'h99AA);
        expect_none("R8 owner eviction silent");
        step();
        expect_none("R8 still silent");
        send(K_WR, 0, 4, '0);
        expect_msg("R8 entry uncached after eviction", M_DATA, 0, 4, 16'h99AA);
    endtask

    task automatic t_nonowner_wb();
        send(K_WR, 1, 6, '0);
        expect_msg("R7 write miss block 6", M_DATA, 1, 6, 16'h0);
        send(K_WB, 3, 6, 16'h1234);
        expect_none("R9 non-owner write-back silent");
        send(K_RD, 2, 6, '0);
        expect_msg("R9 owner unchanged", M_FET, 1, 6, 16'h0);
        send(K_WB, 1, 6, 16'h4321);
        expect_msg("R3 reply block 6", M_DATA, 2, 6, 16'h4321);
    endtask

    task automatic t_inval_req();
        for (int p = 1; p < 4; p++) begin
            send(K_RD, p, 5, '0);
            expect_msg("R2 shared fill block 5", M_DATA, p, 5, 16'h0);
        end
        send(K_INV, 2, 5, '0);
        expect_none("R6 accept cycle");
        step();
        expect_msg("R6 invalidate P1", M_INV, 1, 5, 16'h0);
        step();
        expect_msg("R6 requester skipped, P3 next", M_INV, 3, 5, 16'h0);
        step();
        expect_none("R6 no reply");
        send(K_RD, 0, 5, '0);
        expect_msg("R6 requester owns block", M_FET, 2, 5, 16'h0);
        send(K_WB, 2, 5, 16'h0F0F);
        expect_msg("R3 reply block 5", M_DATA, 0, 5, 16'h0F0F);
    endtask

    task automatic t_sole_sharer();
        send(K_RD, 0, 7, '0);
        expect_msg("R2 read block 7", M_DATA, 0, 7, 16'h0);
        send(K_WR, 0, 7, '0);
        expect_none("R5 accept cycle, only sharer");
        step();
        expect_msg("R5 reply without invalidates", M_DATA, 0, 7, 16'h0);
        send(K_INV, 3, 2, '0);
        expect_msg("R7 invalidate on uncached replies", M_DATA, 3, 2, 16'h0);
        send(K_RD, 1, 2, '0);
        expect_msg("R7 owner after invalidate request", M_FET, 3, 2, 16'h0);
        send(K_WB, 3, 2, 16'hBEEF);
        expect_msg("R3 reply block 2", M_DATA, 1, 2, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_read_shared();
        t_write_shared();
        t_read_modified();
        t_write_modified();
        t_evict();
        t_nonowner_wb();
        t_inval_req();
        t_sole_sharer();
        step();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule